// File: doc/BRIEF.md
# Debug Matchpoint Comparator Bank

This block holds eight hardware matchpoints for an on-chip debug unit. Each matchpoint owns a stored comparison value and an eight-bit control word, both reached by software through a special-purpose-register read/write port. Every clock cycle, each enabled matchpoint selects one quantity observed on the processor pipeline (the instruction fetch address, the data access address or the data access value), compares it against its stored value with one of six relational operators in signed or unsigned form, and reports whether that test holds.

The result is an eight-bit hit vector, one bit per matchpoint, registered so that it appears one cycle after the observed event. Downstream logic combines these hits into watchpoints, counters and traps; none of that is part of this block. Data-side comparisons only count in a cycle that carries a valid load or store of the selected kind, and fetch-side comparisons only in a cycle with a valid fetch.

Top module: `dbg_mp_bank`

## Requirements
- R1: After synchronous reset every stored value and control word is zero, `hit` is zero and `spr_rdata` is zero.
- R2: A write with `spr_we` high to register number 0x3000+i (i = 0..7) loads value i, and to 0x3008+i loads control word i from `spr_wdata[7:0]`; writes to any other number change nothing. `spr_rdata` returns, one cycle after `spr_addr` is presented, the register at that number, or zero for a number outside 0x3000..0x300F.
- R3: Reading a control word returns its eight stored bits in `spr_rdata[7:0]` with all higher bits zero; a value register reads back all 32 bits as written.
- R4: Control bit 0 is the enable; a matchpoint whose enable is 0 never sets its `hit` bit.
- R5: Control bits 3:1 select the test of observed quantity X against stored value V: 1 X==V, 2 X!=V, 3 X<V, 4 X<=V, 5 X>V, 6 X>=V.
- R6: Control bit 4 selects signed (1, two's complement) or unsigned (0) ordering for the tests of R5.
- R7: Control bits 7:5 select X and the qualifying event: 1 `fetch_addr` on `fetch_valid`; 2 `mem_addr` on `load_valid`; 3 `mem_addr` on `store_valid`; 4 `mem_addr` on either; 5 `mem_data` on `load_valid`; 6 `mem_data` on `store_valid`; 7 `mem_data` on either. Without the qualifying event the matchpoint does not hit.
- R8: Operator codes 0 and 7 and source code 0 never produce a hit.
- R9: `hit[i]` reflects the inputs and configuration of the previous clock cycle only; it clears one cycle after the qualifying event goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_addr | input | 16 | Register number for read and write |
| spr_we | input | 1 | Write strobe |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Registered read data for the previous cycle's `spr_addr` |
| fetch_valid | input | 1 | An instruction fetch is observed this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| load_valid | input | 1 | A data load is observed this cycle |
| store_valid | input | 1 | A data store is observed this cycle |
| mem_addr | input | 32 | Data access address |
| mem_data | input | 32 | Data access value |
| hit | output | 8 | Registered matchpoint hits, one bit per matchpoint |

## Verification
Both results of this block are due exactly one clock edge after their stimulus: a hit one edge after the observed event, and read data one edge after the register number is presented. The bench drives every stimulus on a falling edge and samples on the next falling edge, so exactly one rising edge lies between cause and check. For the clearing rule of R9 it removes the event and samples once more a further cycle later, expecting zero.

// File: rtl/dbg_mp_pkg.sv
package dbg_mp_pkg;

  localparam int CTRL_W = 8;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_EQ   = 3'd1,
    OP_NE   = 3'd2,
    OP_LT   = 3'd3,
    OP_LE   = 3'd4,
    OP_GT   = 3'd5,
    OP_GE   = 3'd6,
    OP_RSV  = 3'd7
  } mp_op_e;

  typedef enum logic [2:0] {
    SRC_OFF     = 3'd0,
    SRC_FETCH   = 3'd1,
    SRC_LD_ADDR = 3'd2,
    SRC_ST_ADDR = 3'd3,
    SRC_LS_ADDR = 3'd4,
    SRC_LD_DATA = 3'd5,
    SRC_ST_DATA = 3'd6,
    SRC_LS_DATA = 3'd7
  } mp_src_e;

  // bit 7:5 source, bit 4 signed, bit 3:1 operator, bit 0 enable
  typedef struct packed {
    mp_src_e src;
    logic    sgn;
    mp_op_e  op;
    logic    en;
  } mp_ctrl_t;

endpackage

// File: rtl/dbg_mp_regs.sv
module dbg_mp_regs
  import dbg_mp_pkg::*;
#(
  parameter int NUM_MP = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h3000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              spr_addr,
  input  logic                           spr_we,
  input  logic [DATA_W-1:0]              spr_wdata,
  output logic [DATA_W-1:0]              spr_rdata,
  output logic [NUM_MP-1:0][DATA_W-1:0]  val_o,
  output logic [NUM_MP-1:0][CTRL_W-1:0]  ctrl_o
);

  localparam int IDX_W = (NUM_MP > 1) ? $clog2(NUM_MP) : 1;
  localparam logic [ADDR_W-1:0] NUM_A = ADDR_W'(NUM_MP);
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(2 * NUM_MP);

  logic [ADDR_W-1:0] offs;
  logic              is_val;
  logic              is_ctl;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    offs   = spr_addr - BASE;
    is_val = (offs < NUM_A);
    is_ctl = (offs >= NUM_A) && (offs < TOP_A);
    idx    = offs[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_MP; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        val_o[g]  <= '0;
        ctrl_o[g] <= '0;
      end else if (spr_we) begin
        if (is_val && idx == IDX_W'(g)) val_o[g]  <= spr_wdata;
        if (is_ctl && idx == IDX_W'(g)) ctrl_o[g] <= spr_wdata[CTRL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         spr_rdata <= '0;
    else if (is_val) spr_rdata <= val_o[idx];
    else if (is_ctl) spr_rdata <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_o[idx]};
    else             spr_rdata <= '0;
  end

  // R2: undecoded register numbers read as zero one cycle later
  p_undecoded_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !(is_val || is_ctl) |=> (spr_rdata == '0));

  // R3: control reads carry no bits above the control width
  p_ctrl_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    is_ctl |=> (spr_rdata[DATA_W-1:CTRL_W] == '0));

  // R2: a write to a control slot leaves the value registers alone
  p_ctl_write_keeps_val_r2: assert property (@(posedge clk) disable iff (rst)
    (spr_we && is_ctl) |=> (val_o == $past(val_o)));

endmodule

// File: rtl/dbg_mp_cmp.sv
module dbg_mp_cmp
  import dbg_mp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] ref_val,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_addr,
  input  logic              load_valid,
  input  logic              store_valid,
  input  logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic              match
);

  mp_ctrl_t          c;
  logic [DATA_W-1:0] obs;
  logic              present;
  logic              eq;
  logic              lt;
  logic              res;

  always_comb begin
    c = mp_ctrl_t'(ctrl);
    unique case (c.src)
      SRC_FETCH:   begin obs = fetch_addr; present = fetch_valid; end
      SRC_LD_ADDR: begin obs = mem_addr;   present = load_valid; end
      SRC_ST_ADDR: begin obs = mem_addr;   present = store_valid; end
      SRC_LS_ADDR: begin obs = mem_addr;   present = load_valid | store_valid; end
      SRC_LD_DATA: begin obs = mem_data;   present = load_valid; end
      SRC_ST_DATA: begin obs = mem_data;   present = store_valid; end
      SRC_LS_DATA: begin obs = mem_data;   present = load_valid | store_valid; end
      default:     begin obs = '0;         present = 1'b0; end
    endcase

    eq = (obs == ref_val);
    if (c.sgn) lt = ($signed(obs) < $signed(ref_val));
    else       lt = (obs < ref_val);

    unique case (c.op)
      OP_EQ:   res = eq;
      OP_NE:   res = !eq;
      OP_LT:   res = lt;
      OP_LE:   res = lt | eq;
      OP_GT:   res = !(lt | eq);
      OP_GE:   res = !lt;
      default: res = 1'b0;
    endcase

    match = c.en & present & res;
  end

endmodule

// File: rtl/dbg_mp_bank.sv
module dbg_mp_bank
  import dbg_mp_pkg::*;
#(
  parameter int NUM_MP = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] spr_addr,
  input  logic              spr_we,
  input  logic [DATA_W-1:0] spr_wdata,
  output logic [DATA_W-1:0] spr_rdata,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_addr,
  input  logic              load_valid,
  input  logic              store_valid,
  input  logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic [NUM_MP-1:0] hit
);

  logic [NUM_MP-1:0][DATA_W-1:0] val_q;
  logic [NUM_MP-1:0][CTRL_W-1:0] ctrl_q;
  logic [NUM_MP-1:0]             raw_hit;

  dbg_mp_regs #(
    .NUM_MP (NUM_MP),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BASE   (BASE)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .spr_addr  (spr_addr),
    .spr_we    (spr_we),
    .spr_wdata (spr_wdata),
    .spr_rdata (spr_rdata),
    .val_o     (val_q),
    .ctrl_o    (ctrl_q)
  );

  for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
    dbg_mp_cmp #(.DATA_W(DATA_W)) i_cmp (
      .ctrl        (ctrl_q[g]),
      .ref_val     (val_q[g]),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .load_valid  (load_valid),
      .store_valid (store_valid),
      .mem_addr    (mem_addr),
      .mem_data    (mem_data),
      .match       (raw_hit[g])
    );

    // R4: disabled entries stay silent
    p_disabled_nohit_r4: assert property (@(posedge clk) disable iff (rst)
      !ctrl_q[g][0] |=> !hit[g]);

    // R8: reserved operator codes stay silent
    p_badop_nohit_r8: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[g][3:1] == 3'd0 || ctrl_q[g][3:1] == 3'd7) |=> !hit[g]);

    // R7: fetch source needs a fetch
    p_fetch_gate_r7: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[g][7:5] == 3'd1 && !fetch_valid) |=> !hit[g]);

    // R7: data sources need a load or store
    p_data_gate_r7: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[g][7:5] >= 3'd2 && !load_valid && !store_valid) |=> !hit[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= '0;
    else     hit <= raw_hit;
  end

  // R9: with no event of any kind, no hit follows
  p_no_event_no_hit_r9: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !load_valid && !store_valid) |=> (hit == '0));

endmodule

// File: tb/test_dbg_mp_bank.sv
`timescale 1ns/1ps
module test_dbg_mp_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] spr_addr;
  logic        spr_we;
  logic [31:0] spr_wdata;
  logic [31:0] spr_rdata;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        load_valid;
  logic        store_valid;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic [7:0]  hit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_mp_bank i_dbg_mp_bank (
    .clk(clk), .rst(rst), .spr_addr(spr_addr), .spr_we(spr_we),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .load_valid(load_valid), .store_valid(store_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .hit(hit)
  );

  logic [31:0] pats [6];
  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'h8000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_5678;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spr_wr(input logic [15:0] a, input logic [31:0] d);
    spr_addr = a; spr_wdata = d; spr_we = 1'b1;
    @(negedge clk);
    spr_we = 1'b0;
  endtask

  task automatic spr_rd(input logic [15:0] a, output logic [31:0] d);
    spr_addr = a; spr_we = 1'b0;
    @(negedge clk);
    d = spr_rdata;
  endtask

  function automatic bit exp_test(input int op, input bit sgn, input logic [31:0] x, input logic [31:0] v);
    bit e, l;
    e = (x == v);
    l = sgn ? ($signed(x) < $signed(v)) : (x < v);
    case (op)
      1: return e;
      2: return !e;
      3: return l;
      4: return l || e;
      5: return !l && !e;
      6: return !l;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_src(input int src, input bit fv, input bit lv, input bit sv, input bit addr_eq, input bit data_eq);
    case (src)
      1: return fv;
      2: return lv && addr_eq;
      3: return sv && addr_eq;
      4: return (lv || sv) && addr_eq;
      5: return lv && data_eq;
      6: return sv && data_eq;
      7: return (lv || sv) && data_eq;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] mk_ctrl(input int src, input bit sgn, input int op, input bit en);
    return {3'(src), sgn, 3'(op), en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  ev;
    rst = 1'b1; spr_addr = '0; spr_we = 0; spr_wdata = '0;
    fetch_valid = 0; fetch_addr = '0; load_valid = 0; store_valid = 0;
    mem_addr = '0; mem_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hit", {24'd0, hit}, 32'd0);
    chk("R1 rdata", spr_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      spr_rd(16'h3000 + 16'(i), rd);
      chk("R1 reg zero", rd, 32'd0);
    end

    // R2/R3: decode and readback
    for (int i = 0; i < 8; i++) spr_wr(16'h3000 + 16'(i), 32'hA5A5_0000 + 32'(i * 7919));
    for (int i = 0; i < 8; i++) spr_wr(16'h3008 + 16'(i), 32'hFFFF_FF00 | 32'(i * 37));
    spr_wr(16'h3010, 32'hDEAD_BEEF);
    spr_wr(16'h2FFF, 32'hDEAD_BEEF);
    for (int i = 0; i < 8; i++) begin
      spr_rd(16'h3000 + 16'(i), rd);
      chk("R2 value readback", rd, 32'hA5A5_0000 + 32'(i * 7919));
      spr_rd(16'h3008 + 16'(i), rd);
      chk("R3 control readback", rd, 32'((i * 37) & 8'hFF));
    end
    spr_rd(16'h3010, rd); chk("R2 undecoded read", rd, 32'd0);
    spr_rd(16'h2FFF, rd); chk("R2 undecoded read", rd, 32'd0);

    // R5/R6/R8: matchpoint k uses operator k, fetch source, enabled
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 8; k++) spr_wr(16'h3008 + 16'(k), {24'd0, mk_ctrl(1, s[0], k, 1'b1)});
      for (int vi = 0; vi < 6; vi++) begin
        for (int k = 0; k < 8; k++) spr_wr(16'h3000 + 16'(k), pats[vi]);
        for (int xi = 0; xi < 6; xi++) begin
          logic [7:0] e;
          for (int k = 0; k < 8; k++) e[k] = exp_test(k, s[0], pats[xi], pats[vi]);
          fetch_valid = 1; fetch_addr = pats[xi];
          @(negedge clk);
          fetch_valid = 0;
          chk(s ? "R6 R5 R8 signed sweep" : "R5 R8 unsigned sweep", {24'd0, hit}, {24'd0, e});
        end
      end
    end

    // R7/R9: source select and event gating; matchpoint k uses source k, equality
    for (int k = 0; k < 8; k++) begin
      spr_wr(16'h3000 + 16'(k), 32'h0000_0055);
      spr_wr(16'h3008 + 16'(k), {24'd0, mk_ctrl(k, 1'b0, 1, 1'b1)});
    end
    for (int dpass = 0; dpass < 3; dpass++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] e;
        bit aeq, deq;
        aeq = (dpass != 2);
        deq = (dpass != 1);
        for (int k = 0; k < 8; k++) e[k] = exp_src(k, c[0], c[1], c[2], aeq, deq);
        fetch_valid = c[0]; load_valid = c[1]; store_valid = c[2];
        fetch_addr = 32'h55; mem_addr = aeq ? 32'h55 : 32'h66; mem_data = deq ? 32'h55 : 32'h77;
        @(negedge clk);
        fetch_valid = 0; load_valid = 0; store_valid = 0;
        chk("R7 source gating", {24'd0, hit}, {24'd0, e});
        @(negedge clk);
        chk("R9 hit clears", {24'd0, hit}, 32'd0);
      end
    end

    // R4: same setup, all disabled, every event present
    for (int k = 0; k < 8; k++) spr_wr(16'h3008 + 16'(k), {24'd0, mk_ctrl(k, 1'b0, 1, 1'b0)});
    fetch_valid = 1; load_valid = 1; store_valid = 1;
    fetch_addr = 32'h55; mem_addr = 32'h55; mem_data = 32'h55;
    @(negedge clk);
    chk("R4 disabled no hit", {24'd0, hit}, 32'd0);
    // re-enable matchpoint 3 only while events held
    spr_wr(16'h3008 + 16'd3, {24'd0, mk_ctrl(3, 1'b0, 1, 1'b1)});
    @(negedge clk);
    ev = 8'h08;
    chk("R4 single enable", {24'd0, hit}, {24'd0, ev});
    fetch_valid = 0; load_valid = 0; store_valid = 0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule